// File: doc/BRIEF.md
# Neighbor Tag Capture Cache

A DRAM cache that keeps every 64-byte data block beside its 8-byte tag in the same DRAM row returns, on each demand read, the tag and data of the requested entry plus the tag of the entry that follows it in the row. This block keeps that extra tag so it is not thrown away. It keeps a few of them per DRAM bank. When a later request is about to probe the DRAM cache for that following line, the controller first asks this block. If the block holds the line it answers known-hit or known-miss at once, and a miss-detection probe on the DRAM bus can be skipped. Otherwise it answers unknown and the controller probes as usual.

Each bank owns a small table of entries. Each entry holds the neighbor's line address and a tag word made of a presence flag and tag bits. New captures replace entries in round-robin order. The controller reports fills, writeback fills and evictions through an update port. The table follows those changes at once, and a lookup made in the same cycle already sees the new state, so a stale tag never gives a wrong answer. A line address is split into a row field in the upper bits and a column (entry slot within the row) in the lower bits. The neighbor of column c is column c+1 of the same row. The last slot of a row has no neighbor inside the row.

Top module: `nbr_tag_cache`

## Requirements
- R1: After synchronous reset, res_valid is 0, res_code is 00 and every table entry is empty, so any lookup answers unknown (00).
- R2: A capture of demand line {row, col} in bank b stores line {row, col+1} in bank b with the supplied presence flag and tag bits. A lookup of that line in that bank with equal tag bits, when the stored flag is 1, answers known-hit (01).
- R3: A lookup that matches a stored line answers known-miss (10) when the stored presence flag is 0 or the stored tag bits differ from the request tag. Code 11 never appears.
- R4: A lookup whose line is not held in the requested bank answers unknown (00), even if another bank holds that line.
- R5: A capture whose demand column is ROW_LINES-1 (the last slot of the row) stores nothing. A capture from column ROW_LINES-2 stores the last slot normally.
- R6: Each bank holds ENTRIES entries. A capture of a line the bank does not hold replaces the entry at the bank's round-robin pointer, which starts at entry 0 and then advances with wrap. A capture of a line the bank already holds rewrites that entry in place and leaves the pointer where it is.
- R7: Update op code 00 (fill) sets the held line's flag to 1 with the new tag bits. Code 01 (evict) clears the flag, so the line reads known-miss. Code 10 (drop) frees the entry, so the line reads unknown. An update to a line that is not held changes nothing.
- R8: A lookup in the same cycle as an update to the same bank and line answers from the state after that update.
- R9: A lookup in the same cycle as any capture to the same bank answers unknown. A capture to a different bank does not disturb the lookup.
- R10: When a capture and an update name the same neighbor line in the same bank in the same cycle, the capture is discarded and the update is applied.
- R11: res_valid is 1 exactly one clock after a cycle with lkp_valid high and 0 otherwise. res_code is 00 whenever res_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_valid | input | 1 | Demand-read burst returned, carrying a neighbor tag |
| cap_bank | input | BANK_W | DRAM bank of the demand read |
| cap_line | input | LINE_W | Demand line address {row, col} |
| cap_tag_vld | input | 1 | Presence flag of the neighbor's tag word |
| cap_tag | input | TAG_W | Tag bits of the neighbor's tag word |
| upd_valid | input | 1 | Fill, writeback fill or eviction notice |
| upd_bank | input | BANK_W | Bank of the updated line |
| upd_line | input | LINE_W | Updated line address |
| upd_op | input | 2 | 00 fill, 01 evict, 10 drop |
| upd_tag | input | TAG_W | New tag bits for a fill |
| lkp_valid | input | 1 | Lookup request |
| lkp_bank | input | BANK_W | Bank of the lookup |
| lkp_line | input | LINE_W | Line address looked up |
| lkp_tag | input | TAG_W | Tag bits of the request |
| res_valid | output | 1 | Result of last cycle's lookup is present |
| res_code | output | 2 | 00 unknown, 01 known-hit, 10 known-miss |

## Verification
Lookups are tried against a captured neighbor with an equal tag, a different tag and a cleared flag. This tells the hit path apart from the two miss causes. Lookups of the demand line itself, of the same line in another bank, and of the slot after a row's end tell a real address match apart from a partial one. Replacement is probed with one more capture than a bank holds, followed by a rewrite of a held line and one further capture. The second step shows whether the pointer moved on the rewrite. Same-cycle pairings (lookup with update, lookup with capture in the same and in another bank, capture with update on one line) set the forwarding and priority rules apart from plain sequential behaviour.

// File: rtl/ntc_pkg.sv
package ntc_pkg;

    typedef enum logic [1:0] {
        RES_UNKNOWN = 2'b00,
        RES_HIT     = 2'b01,
        RES_MISS    = 2'b10
    } ntc_res_e;

    typedef enum logic [1:0] {
        UPD_FILL  = 2'b00,
        UPD_EVICT = 2'b01,
        UPD_DROP  = 2'b10
    } ntc_upd_e;

    // Verdict for a line that is held: hit only when the tag is present and equal.
    function automatic ntc_res_e judge(input logic present, input logic same_tag);
        return (present && same_tag) ? RES_HIT : RES_MISS;
    endfunction

endpackage

// File: rtl/ntc_neighbor.sv
module ntc_neighbor #(
    parameter int ROW_W     = 10,
    parameter int ROW_LINES = 28,
    parameter int COL_W     = 5
) (
    input  logic [ROW_W+COL_W-1:0] line_i,
    output logic [ROW_W+COL_W-1:0] nb_line_o,
    output logic                   nb_ok_o
);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(ROW_LINES - 1);

    logic [COL_W-1:0] col;
    logic [COL_W-1:0] col_next;

    assign col      = line_i[COL_W-1:0];
    assign col_next = col + 1'b1;
    assign nb_ok_o  = (col < LAST_COL);
    assign nb_line_o = {line_i[ROW_W+COL_W-1:COL_W], col_next};

endmodule

// File: rtl/ntc_bank.sv
module ntc_bank
    import ntc_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int LINE_W  = 15,
    parameter int TAG_W   = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [LINE_W-1:0] cap_line,
    input  logic              cap_tag_vld,
    input  logic [TAG_W-1:0]  cap_tag,
    input  logic              upd_en,
    input  logic [LINE_W-1:0] upd_line,
    input  logic [1:0]        upd_op,
    input  logic [TAG_W-1:0]  upd_tag,
    input  logic [LINE_W-1:0] lkp_line,
    input  logic [TAG_W-1:0]  lkp_tag,
    output logic [1:0]        res_o
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic              ent_v    [ENTRIES];
    logic [LINE_W-1:0] ent_line [ENTRIES];
    logic              ent_tv   [ENTRIES];
    logic [TAG_W-1:0]  ent_tag  [ENTRIES];
    logic [IDX_W-1:0]  rr_ptr;

    logic [ENTRIES-1:0] cap_hit;
    logic [ENTRIES-1:0] upd_hit;
    logic [ENTRIES-1:0] lkp_hit;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_match
            assign cap_hit[g] = ent_v[g] && (ent_line[g] == cap_line);
            assign upd_hit[g] = ent_v[g] && (ent_line[g] == upd_line);
            assign lkp_hit[g] = ent_v[g] && (ent_line[g] == lkp_line);
        end
    endgenerate

    // Capture loses to an update naming the same line this cycle.
    logic             cap_take;
    logic             cap_reuse;
    logic [IDX_W-1:0] cap_idx;
    logic [IDX_W-1:0] cap_slot;
    ntc_upd_e         op;

    assign op        = ntc_upd_e'(upd_op);
    assign cap_take  = cap_en && !(upd_en && (upd_line == cap_line));
    assign cap_reuse = |cap_hit;

    always_comb begin
        cap_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (cap_hit[i]) cap_idx = IDX_W'(i);
        end
    end

    assign cap_slot = cap_reuse ? cap_idx : rr_ptr;

    // Lookup sees the state as it will be after this cycle's update.
    always_comb begin
        logic             tv;
        logic [TAG_W-1:0] tg;
        logic             gone;
        ntc_res_e         r;
        tv   = 1'b0;
        tg   = '0;
        gone = 1'b0;
        r    = RES_UNKNOWN;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lkp_hit[i]) begin
                tv   = ent_tv[i];
                tg   = ent_tag[i];
                gone = 1'b0;
                if (upd_en && upd_hit[i]) begin
                    case (op)
                        UPD_FILL:  begin tv = 1'b1; tg = upd_tag; end
                        UPD_EVICT: tv = 1'b0;
                        UPD_DROP:  gone = 1'b1;
                        default:   ;
                    endcase
                end
                r = gone ? RES_UNKNOWN : judge(tv, tg == lkp_tag);
            end
        end
        res_o = r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                ent_v[i]    <= 1'b0;
                ent_line[i] <= '0;
                ent_tv[i]   <= 1'b0;
                ent_tag[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (upd_en && upd_hit[i]) begin
                    case (op)
                        UPD_FILL: begin
                            ent_tv[i]  <= 1'b1;
                            ent_tag[i] <= upd_tag;
                        end
                        UPD_EVICT: ent_tv[i] <= 1'b0;
                        UPD_DROP:  ent_v[i]  <= 1'b0;
                        default:   ;
                    endcase
                end
            end
            if (cap_take) begin
                ent_v[cap_slot]    <= 1'b1;
                ent_line[cap_slot] <= cap_line;
                ent_tv[cap_slot]   <= cap_tag_vld;
                ent_tag[cap_slot]  <= cap_tag;
                if (!cap_reuse) begin
                    rr_ptr <= (rr_ptr == LAST_IDX) ? '0 : rr_ptr + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/nbr_tag_cache.sv
module nbr_tag_cache
    import ntc_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ENTRIES   = 4,
    parameter int ROW_W     = 10,
    parameter int ROW_LINES = 28,
    parameter int TAG_W     = 20,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int COL_W    = (ROW_LINES > 1) ? $clog2(ROW_LINES) : 1,
    localparam int LINE_W   = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_valid,
    input  logic [BANK_W-1:0] cap_bank,
    input  logic [LINE_W-1:0] cap_line,
    input  logic              cap_tag_vld,
    input  logic [TAG_W-1:0]  cap_tag,
    input  logic              upd_valid,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [LINE_W-1:0] upd_line,
    input  logic [1:0]        upd_op,
    input  logic [TAG_W-1:0]  upd_tag,
    input  logic              lkp_valid,
    input  logic [BANK_W-1:0] lkp_bank,
    input  logic [LINE_W-1:0] lkp_line,
    input  logic [TAG_W-1:0]  lkp_tag,
    output logic              res_valid,
    output logic [1:0]        res_code
);
    logic [LINE_W-1:0] nb_line;
    logic              nb_ok;
    logic [1:0]        bank_res [NUM_BANKS];

    ntc_neighbor #(
        .ROW_W    (ROW_W),
        .ROW_LINES(ROW_LINES),
        .COL_W    (COL_W)
    ) nb_i (
        .line_i   (cap_line),
        .nb_line_o(nb_line),
        .nb_ok_o  (nb_ok)
    );

    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic cap_en_b;
            logic upd_en_b;
            assign cap_en_b = cap_valid && nb_ok && (cap_bank == BANK_W'(b));
            assign upd_en_b = upd_valid && (upd_bank == BANK_W'(b));

            ntc_bank #(
                .ENTRIES(ENTRIES),
                .LINE_W (LINE_W),
                .TAG_W  (TAG_W)
            ) bank_i (
                .clk        (clk),
                .rst        (rst),
                .cap_en     (cap_en_b),
                .cap_line   (nb_line),
                .cap_tag_vld(cap_tag_vld),
                .cap_tag    (cap_tag),
                .upd_en     (upd_en_b),
                .upd_line   (upd_line),
                .upd_op     (upd_op),
                .upd_tag    (upd_tag),
                .lkp_line   (lkp_line),
                .lkp_tag    (lkp_tag),
                .res_o      (bank_res[b])
            );
        end
    endgenerate

    logic       bank_busy;
    logic [1:0] res_next;

    assign bank_busy = cap_valid && (cap_bank == lkp_bank);

    always_comb begin
        res_next = RES_UNKNOWN;
        if (lkp_valid && !bank_busy) res_next = bank_res[lkp_bank];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_code  <= RES_UNKNOWN;
        end else begin
            res_valid <= lkp_valid;
            res_code  <= res_next;
        end
    end

endmodule

// File: rtl/ntc_checks.sv
module ntc_checks #(
    parameter int BANK_W = 2,
    parameter int LINE_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              cap_valid,
    input logic [BANK_W-1:0] cap_bank,
    input logic              upd_valid,
    input logic [BANK_W-1:0] upd_bank,
    input logic [LINE_W-1:0] upd_line,
    input logic [1:0]        upd_op,
    input logic              lkp_valid,
    input logic [BANK_W-1:0] lkp_bank,
    input logic [LINE_W-1:0] lkp_line,
    input logic              res_valid,
    input logic [1:0]        res_code
);
    p_result_follows_r11: assert property (@(posedge clk) disable iff (rst)
        lkp_valid |=> res_valid);

    p_no_spurious_result_r11: assert property (@(posedge clk) disable iff (rst)
        !lkp_valid |=> !res_valid);

    p_idle_code_zero_r11: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (res_code == 2'b00));

    p_legal_code_r3: assert property (@(posedge clk) disable iff (rst)
        res_code != 2'b11);

    p_capture_blocks_bank_r9: assert property (@(posedge clk) disable iff (rst)
        (lkp_valid && cap_valid && (cap_bank == lkp_bank)) |=> (res_code == 2'b00));

    p_drop_seen_same_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        (lkp_valid && upd_valid && (upd_op == 2'b10) && (upd_bank == lkp_bank)
         && (upd_line == lkp_line)) |=> (res_code == 2'b00));

endmodule

bind nbr_tag_cache ntc_checks #(
    .BANK_W(BANK_W),
    .LINE_W(LINE_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .cap_valid(cap_valid),
    .cap_bank (cap_bank),
    .upd_valid(upd_valid),
    .upd_bank (upd_bank),
    .upd_line (upd_line),
    .upd_op   (upd_op),
    .lkp_valid(lkp_valid),
    .lkp_bank (lkp_bank),
    .lkp_line (lkp_line),
    .res_valid(res_valid),
    .res_code (res_code)
);

// File: tb/nbr_tag_cache_tb_top.sv
module nbr_tag_cache_tb_top;

    localparam int BANK_W = 2;
    localparam int ROW_W  = 10;
    localparam int COL_W  = 5;
    localparam int LINE_W = ROW_W + COL_W;
    localparam int TAG_W  = 20;

    localparam logic [1:0] UNK  = 2'b00;
    localparam logic [1:0] HIT  = 2'b01;
    localparam logic [1:0] MISS = 2'b10;
    localparam logic [1:0] OP_FILL  = 2'b00;
    localparam logic [1:0] OP_EVICT = 2'b01;
    localparam logic [1:0] OP_DROP  = 2'b10;

    logic              clk = 1'b0;
    logic              rst;
    logic              cap_valid;
    logic [BANK_W-1:0] cap_bank;
    logic [LINE_W-1:0] cap_line;
    logic              cap_tag_vld;
    logic [TAG_W-1:0]  cap_tag;
    logic              upd_valid;
    logic [BANK_W-1:0] upd_bank;
    logic [LINE_W-1:0] upd_line;
    logic [1:0]        upd_op;
    logic [TAG_W-1:0]  upd_tag;
    logic              lkp_valid;
    logic [BANK_W-1:0] lkp_bank;
    logic [LINE_W-1:0] lkp_line;
    logic [TAG_W-1:0]  lkp_tag;
    logic              res_valid;
    logic [1:0]        res_code;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    nbr_tag_cache dut_i (
        .clk(clk), .rst(rst),
        .cap_valid(cap_valid), .cap_bank(cap_bank), .cap_line(cap_line),
        .cap_tag_vld(cap_tag_vld), .cap_tag(cap_tag),
        .upd_valid(upd_valid), .upd_bank(upd_bank), .upd_line(upd_line),
        .upd_op(upd_op), .upd_tag(upd_tag),
        .lkp_valid(lkp_valid), .lkp_bank(lkp_bank), .lkp_line(lkp_line),
        .lkp_tag(lkp_tag),
        .res_valid(res_valid), .res_code(res_code)
    );

    function automatic logic [LINE_W-1:0] ln(input int row, input int col);
        return {ROW_W'(row), COL_W'(col)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        cap_valid = 1'b0; cap_bank = '0; cap_line = '0; cap_tag_vld = 1'b0; cap_tag = '0;
        upd_valid = 1'b0; upd_bank = '0; upd_line = '0; upd_op = '0; upd_tag = '0;
        lkp_valid = 1'b0; lkp_bank = '0; lkp_line = '0; lkp_tag = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_cap(input int bank, input int row, input int col, input logic tv, input int tag);
        cap_valid = 1'b1; cap_bank = BANK_W'(bank); cap_line = ln(row, col);
        cap_tag_vld = tv; cap_tag = TAG_W'(tag);
    endtask

    task automatic set_upd(input int bank, input int row, input int col, input logic [1:0] op, input int tag);
        upd_valid = 1'b1; upd_bank = BANK_W'(bank); upd_line = ln(row, col);
        upd_op = op; upd_tag = TAG_W'(tag);
    endtask

    task automatic capture(input int bank, input int row, input int col, input logic tv, input int tag);
        set_cap(bank, row, col, tv, tag);
        tick();
        clear_all();
    endtask

    task automatic update(input int bank, input int row, input int col, input logic [1:0] op, input int tag);
        set_upd(bank, row, col, op, tag);
        tick();
        clear_all();
    endtask

    // Drives a lookup together with whatever else is already set, checks the registered result.
    task automatic look(input string req, input int bank, input int row, input int col,
                        input int tag, input logic [1:0] exp);
        lkp_valid = 1'b1; lkp_bank = BANK_W'(bank); lkp_line = ln(row, col); lkp_tag = TAG_W'(tag);
        tick();
        chk({req, " res_valid"}, 32'(res_valid), 32'd1);
        chk({req, " res_code"}, 32'(res_code), 32'(exp));
        clear_all();
    endtask

    task automatic t_reset();
        chk("R1 reset res_valid", 32'(res_valid), 32'd0);
        chk("R1 reset res_code", 32'(res_code), 32'd0);
        look("R1 empty table", 0, 1, 1, 0, UNK);
        look("R1 empty table bank3", 3, 0, 0, 0, UNK);
    endtask

    task automatic t_basic();
        capture(1, 5, 3, 1'b1, 'hABCDE);
        look("R2 neighbor equal tag", 1, 5, 4, 'hABCDE, HIT);
        look("R3 neighbor other tag", 1, 5, 4, 'h12345, MISS);
        look("R4 demand line not held", 1, 5, 3, 'hABCDE, UNK);
        look("R4 other bank", 2, 5, 4, 'hABCDE, UNK);
        capture(1, 6, 0, 1'b0, 'h11);
        look("R3 absent flag", 1, 6, 1, 'h11, MISS);
    endtask

    task automatic t_row_end();
        capture(2, 7, 27, 1'b1, 5);
        look("R5 next row slot0", 2, 8, 0, 5, UNK);
        look("R5 col past end", 2, 7, 28, 5, UNK);
        capture(2, 7, 26, 1'b1, 6);
        look("R5 last slot captured", 2, 7, 27, 6, HIT);
    endtask

    task automatic t_round_robin();
        for (int c = 0; c < 4; c++) capture(3, 1, c, 1'b1, 10 + c);
        capture(3, 1, 10, 1'b1, 20);
        look("R6 oldest replaced", 3, 1, 1, 10, UNK);
        look("R6 second kept", 3, 1, 2, 11, HIT);
        look("R6 new entry", 3, 1, 11, 20, HIT);
        capture(3, 1, 1, 1'b1, 99);
        look("R6 rewrite in place", 3, 1, 2, 99, HIT);
        look("R6 rewrite keeps others", 3, 1, 3, 12, HIT);
        capture(3, 1, 20, 1'b1, 30);
        look("R6 pointer held on rewrite", 3, 1, 2, 99, UNK);
        look("R6 next slot survives", 3, 1, 3, 12, HIT);
        look("R6 newest", 3, 1, 21, 30, HIT);
    endtask

    task automatic t_updates();
        capture(0, 2, 0, 1'b1, 'h100);
        update(0, 2, 1, OP_FILL, 'h200);
        look("R7 fill new tag", 0, 2, 1, 'h200, HIT);
        look("R7 fill old tag", 0, 2, 1, 'h100, MISS);
        update(0, 2, 1, OP_EVICT, 0);
        look("R7 evict", 0, 2, 1, 'h200, MISS);
        update(0, 2, 1, OP_FILL, 'h300);
        look("R7 fill after evict", 0, 2, 1, 'h300, HIT);
        update(0, 2, 1, OP_DROP, 0);
        look("R7 drop", 0, 2, 1, 'h300, UNK);
        update(0, 2, 9, OP_FILL, 1);
        look("R7 update not held", 0, 2, 9, 1, UNK);
    endtask

    task automatic t_forward();
        capture(0, 3, 0, 1'b1, 'h40);
        set_upd(0, 3, 1, OP_EVICT, 0);
        look("R8 evict same cycle", 0, 3, 1, 'h40, MISS);
        look("R8 evict persisted", 0, 3, 1, 'h40, MISS);
        set_upd(0, 3, 1, OP_FILL, 'h41);
        look("R8 fill same cycle", 0, 3, 1, 'h41, HIT);
        set_upd(0, 3, 1, OP_DROP, 0);
        look("R8 drop same cycle", 0, 3, 1, 'h41, UNK);
    endtask

    task automatic t_priority();
        set_cap(1, 9, 0, 1'b1, 1);
        look("R9 same bank capture", 1, 5, 4, 'hABCDE, UNK);
        look("R9 entry intact", 1, 5, 4, 'hABCDE, HIT);
        set_cap(2, 12, 0, 1'b1, 2);
        look("R9 other bank capture", 1, 5, 4, 'hABCDE, HIT);
    endtask

    task automatic t_clash();
        capture(0, 4, 0, 1'b1, 7);
        look("R10 setup", 0, 4, 1, 7, HIT);
        set_cap(0, 4, 0, 1'b1, 8);
        set_upd(0, 4, 1, OP_FILL, 9);
        tick();
        clear_all();
        look("R10 update tag kept", 0, 4, 1, 9, HIT);
        look("R10 capture tag dropped", 0, 4, 1, 8, MISS);
    endtask

    task automatic t_timing();
        look("R11 lookup", 1, 5, 4, 'hABCDE, HIT);
        tick();
        chk("R11 idle res_valid", 32'(res_valid), 32'd0);
        chk("R11 idle res_code", 32'(res_code), 32'd0);
    endtask

    initial begin
        for (int n = 0; n < 100000; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        clear_all();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_row_end();
        t_round_robin();
        t_updates();
        t_forward();
        t_priority();
        t_clash();
        t_timing();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule